// File: doc/BRIEF.md
# Link Reset Request Relay

This block carries the hardware reset request of a serial radio link in both directions. On the receive side it follows the control words of each hyperframe. It picks out the reset bit of the control word at basic-frame index 130, which is bit 0 of that word. It raises a request output to the local application only after that bit has arrived set in ten hyperframes in a row.

On the transmit side it samples a local assert input on each rising clock edge. It places that value as the reset bit of the outgoing control word at the same index. Each direction has its own enable input. A clear receive enable holds the request output low. A clear transmit enable forces the outgoing reset bit to zero.

Both directions use the same slot tracker. The tracker counts control-word strobes from the last strobe flagged as the start of a hyperframe, and it marks the one strobe whose index matches the reset slot. Until the first start-of-hyperframe flag arrives, the tracker marks no strobe in that direction.

The receive side is a three-state machine with these states:
- `RX_CLEAR`: no set bit is pending.
- `RX_COUNT`: one or more consecutive set bits, fewer than the threshold.
- `RX_SAT`: the threshold has been reached.

Its transitions are:
- Clear → Count when a slot brings a set bit and the threshold is not yet reached.
- Count → Count while set bits keep arriving below the threshold.
- Clear or Count → Sat when a set bit brings the count to the threshold.
- Sat → Sat while the bits stay set. The count saturates.
- Any state → Clear when a slot brings a clear bit.

The transmit side is a two-state machine. Its states are `TX_QUIET` and `TX_SEND`. On every edge it moves to `TX_SEND` when both the transmit enable and the assert input are high, and to `TX_QUIET` otherwise.

Top module: `cw_reset_relay`

## Requirements
- R1: While reset is applied and in the cycle after it is released, `rst_req_out`, `rx_rst_raw` and `tx_rst_bit` are all 0.
- R2: Only a strobe at index `SLOT_IDX` is a reset slot. Index 0 is the strobe with its start flag high, and each further strobe adds one, wrapping after `HF_LEN-1`. Strobes that arrive before the first start flag in a direction are not slots. Bits received in non-slot words have no effect on `rst_req_out` or `rx_rst_raw`.
- R3: When `rx_en` is 1, `rst_req_out` rises at the clock edge of the `REQ_COUNT`-th consecutive slot whose bit is 1, and is still 0 after `REQ_COUNT-1` such slots.
- R4: A slot with bit 0 returns the consecutive count to zero, so a later request needs `REQ_COUNT` fresh set slots.
- R5: Once set, `rst_req_out` stays 1 while further slots bring 1. It falls at the edge of the first slot that brings 0.
- R6: `rst_req_out` is 0 one edge after `rx_en` goes low, and counting continues meanwhile. Raising `rx_en` while the count is saturated sets `rst_req_out` at the next edge.
- R7: `rx_rst_raw` holds the bit received in the most recent reset slot, updated at that slot's edge.
- R8: During a transmit slot strobe, `tx_rst_bit` equals `rst_assert_in` as sampled at the previous rising edge, provided `tx_en` was 1 at that edge.
- R9: `tx_rst_bit` is 0 outside a transmit slot strobe. It is also 0 in a slot when `tx_en` was 0 at the previous edge, whatever `rst_assert_in` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive-direction request enable |
| tx_en | input | 1 | Transmit-direction reset enable |
| rx_cw_stb | input | 1 | One pulse per received basic-frame control word |
| rx_hf_start | input | 1 | With `rx_cw_stb`: this word is index 0 of a hyperframe |
| rx_rst_bit | input | 1 | Bit 0 of the received control word |
| tx_cw_stb | input | 1 | One pulse per transmit control-word slot |
| tx_hf_start | input | 1 | With `tx_cw_stb`: this slot is index 0 of a hyperframe |
| rst_assert_in | input | 1 | Local request to send a reset to the link partner |
| tx_rst_bit | output | 1 | Bit 0 value for the current transmit control word |
| rst_req_out | output | 1 | Reset request received from the link partner |
| rx_rst_raw | output | 1 | Last received reset-slot bit, for observation |

## Verification
The bench builds the relay with `HF_LEN=8` and `SLOT_IDX=5`. The short hyperframe makes each set or clear slot cost eight cycles, so runs of ten and more consecutive slots, threshold misses by one, and broken runs all fit in a few hundred cycles. Every non-slot word is also driven, so stray bits can be checked for no effect. `REQ_COUNT` keeps its default of 10. The boundary between nine and ten set slots is therefore tested at the real threshold, together with the saturation and enable-gating behaviour that follows it.

// File: rtl/cw_reset_pkg.sv
package cw_reset_pkg;

    typedef enum logic [1:0] {
        RX_CLEAR = 2'd0,
        RX_COUNT = 2'd1,
        RX_SAT   = 2'd2
    } rx_state_e;

    typedef enum logic {
        TX_QUIET = 1'b0,
        TX_SEND  = 1'b1
    } tx_state_e;

    localparam int DIR_RX = 0;
    localparam int DIR_TX = 1;
    localparam int NUM_DIRS = 2;

endpackage

// File: rtl/cw_slot_tracker.sv
module cw_slot_tracker #(
    parameter int HF_LEN   = 256,
    parameter int SLOT_IDX = 130
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cw_stb,
    input  logic hf_start,
    output logic slot_hit
);
    localparam int IDX_W = (HF_LEN > 1) ? $clog2(HF_LEN) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HF_LEN - 1);
    localparam logic [IDX_W-1:0] HIT_IDX  = IDX_W'(SLOT_IDX);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] cur_idx;
    logic             sync_q;

    // index carried by the strobe of this cycle
    always_comb begin
        if (hf_start) begin
            cur_idx = '0;
        end else if (idx_q == LAST_IDX) begin
            cur_idx = '0;
        end else begin
            cur_idx = idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= LAST_IDX;
            sync_q <= 1'b0;
        end else if (cw_stb) begin
            idx_q <= cur_idx;
            if (hf_start) begin
                sync_q <= 1'b1;
            end
        end
    end

    assign slot_hit = cw_stb && (hf_start || sync_q) && (cur_idx == HIT_IDX);

endmodule

// File: rtl/rx_reset_fsm.sv
module rx_reset_fsm
    import cw_reset_pkg::*;
#(
    parameter int REQ_COUNT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_hit,
    input  logic rx_bit,
    input  logic rx_en,
    output logic req_o,
    output logic raw_o
);
    localparam int CNT_W = $clog2(REQ_COUNT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(REQ_COUNT);

    rx_state_e        state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             req_q;
    logic             raw_q;

    // next state and run length
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        if (slot_hit) begin
            unique case (state_q)
                RX_CLEAR, RX_COUNT: begin
                    if (!rx_bit) begin
                        state_n = RX_CLEAR;
                        cnt_n   = '0;
                    end else begin
                        cnt_n   = cnt_q + 1'b1;
                        state_n = (cnt_n == CNT_MAX) ? RX_SAT : RX_COUNT;
                    end
                end
                RX_SAT: begin
                    if (!rx_bit) begin
                        state_n = RX_CLEAR;
                        cnt_n   = '0;
                    end
                end
                default: begin
                    state_n = RX_CLEAR;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_CLEAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            raw_q <= 1'b0;
        end else begin
            req_q <= rx_en && (state_n == RX_SAT);
            if (slot_hit) begin
                raw_q <= rx_bit;
            end
        end
    end

    assign req_o = req_q;
    assign raw_o = raw_q;

endmodule

// File: rtl/tx_reset_inserter.sv
module tx_reset_inserter
    import cw_reset_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic slot_hit,
    input  logic tx_en,
    input  logic assert_in,
    output logic tx_bit
);
    tx_state_e state_q, state_n;

    always_comb begin
        unique case (state_q)
            TX_QUIET: state_n = (tx_en && assert_in) ? TX_SEND : TX_QUIET;
            TX_SEND:  state_n = (tx_en && assert_in) ? TX_SEND : TX_QUIET;
            default:  state_n = TX_QUIET;
        endcase
    end

    // state register: samples the local assert at each rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_QUIET;
        end else begin
            state_q <= state_n;
        end
    end

    // output: bit 0 of the reset control word, zero elsewhere
    always_comb begin
        tx_bit = slot_hit && (state_q == TX_SEND);
    end

endmodule

// File: rtl/cw_reset_relay.sv
module cw_reset_relay
    import cw_reset_pkg::*;
#(
    parameter int HF_LEN    = 256,
    parameter int SLOT_IDX  = 130,
    parameter int REQ_COUNT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic tx_en,
    input  logic rx_cw_stb,
    input  logic rx_hf_start,
    input  logic rx_rst_bit,
    input  logic tx_cw_stb,
    input  logic tx_hf_start,
    input  logic rst_assert_in,
    output logic tx_rst_bit,
    output logic rst_req_out,
    output logic rx_rst_raw
);
    logic [NUM_DIRS-1:0] dir_stb;
    logic [NUM_DIRS-1:0] dir_start;
    logic [NUM_DIRS-1:0] dir_hit;

    assign dir_stb[DIR_RX]   = rx_cw_stb;
    assign dir_start[DIR_RX] = rx_hf_start;
    assign dir_stb[DIR_TX]   = tx_cw_stb;
    assign dir_start[DIR_TX] = tx_hf_start;

    for (genvar g = 0; g < NUM_DIRS; g++) begin : g_track
        cw_slot_tracker #(
            .HF_LEN   (HF_LEN),
            .SLOT_IDX (SLOT_IDX)
        ) u_track (
            .clk      (clk),
            .rst_n    (rst_n),
            .cw_stb   (dir_stb[g]),
            .hf_start (dir_start[g]),
            .slot_hit (dir_hit[g])
        );
    end

    rx_reset_fsm #(
        .REQ_COUNT (REQ_COUNT)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_hit (dir_hit[DIR_RX]),
        .rx_bit   (rx_rst_bit),
        .rx_en    (rx_en),
        .req_o    (rst_req_out),
        .raw_o    (rx_rst_raw)
    );

    tx_reset_inserter u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_hit  (dir_hit[DIR_TX]),
        .tx_en     (tx_en),
        .assert_in (rst_assert_in),
        .tx_bit    (tx_rst_bit)
    );

endmodule

// File: rtl/cw_reset_relay_chk.sv
module cw_reset_relay_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_en,
    input logic tx_en,
    input logic rx_cw_stb,
    input logic rx_rst_bit,
    input logic tx_cw_stb,
    input logic rst_assert_in,
    input logic tx_rst_bit,
    input logic rst_req_out,
    input logic rx_rst_raw
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!rst_req_out && !rx_rst_raw));

    // R6
    req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_out |-> $past(rx_en));

    // R5
    req_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req_out) |-> ($past(!rx_en) || $past(rx_cw_stb && !rx_rst_bit)));

    // R7
    raw_moves_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_rst_raw) |-> $past(rx_cw_stb));

    // R9
    tx_outside_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_cw_stb |-> !tx_rst_bit);

    // R8
    tx_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rst_bit |-> ($past(tx_en) && $past(rst_assert_in)));

endmodule

bind cw_reset_relay cw_reset_relay_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_en         (rx_en),
    .tx_en         (tx_en),
    .rx_cw_stb     (rx_cw_stb),
    .rx_rst_bit    (rx_rst_bit),
    .tx_cw_stb     (tx_cw_stb),
    .rst_assert_in (rst_assert_in),
    .tx_rst_bit    (tx_rst_bit),
    .rst_req_out   (rst_req_out),
    .rx_rst_raw    (rx_rst_raw)
);

// File: tb/cw_reset_relay_bench.sv
module cw_reset_relay_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HF_LEN     = 8;
    localparam int SLOT_IDX   = 5;
    localparam int REQ_COUNT  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0, tx_en = 1'b0;
    logic rx_cw_stb = 1'b0, rx_hf_start = 1'b0, rx_rst_bit = 1'b0;
    logic tx_cw_stb = 1'b0, tx_hf_start = 1'b0, rst_assert_in = 1'b0;
    logic tx_rst_bit, rst_req_out, rx_rst_raw;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cw_reset_relay #(
        .HF_LEN    (HF_LEN),
        .SLOT_IDX  (SLOT_IDX),
        .REQ_COUNT (REQ_COUNT)
    ) u_cw_reset_relay (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_en         (rx_en),
        .tx_en         (tx_en),
        .rx_cw_stb     (rx_cw_stb),
        .rx_hf_start   (rx_hf_start),
        .rx_rst_bit    (rx_rst_bit),
        .tx_cw_stb     (tx_cw_stb),
        .tx_hf_start   (tx_hf_start),
        .rst_assert_in (rst_assert_in),
        .tx_rst_bit    (tx_rst_bit),
        .rst_req_out   (rst_req_out),
        .rx_rst_raw    (rx_rst_raw)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // one received hyperframe; strobe every cycle, state checked after
    task automatic rx_hf(input logic slot_bit, input logic other_bit, input logic synced);
        for (int i = 0; i < HF_LEN; i++) begin
            @(negedge clk);
            rx_cw_stb   = 1'b1;
            rx_hf_start = synced && (i == 0);
            rx_rst_bit  = (i == SLOT_IDX) ? slot_bit : other_bit;
        end
        @(negedge clk);
        rx_cw_stb   = 1'b0;
        rx_hf_start = 1'b0;
        rx_rst_bit  = 1'b0;
    endtask

    task automatic rx_run(input int n, input logic slot_bit);
        for (int k = 0; k < n; k++) rx_hf(slot_bit, 1'b0, 1'b1);
    endtask

    // one transmit hyperframe, checking the output of each strobe
    task automatic tx_hf(input logic a, input logic en, input logic synced, input string req);
        @(negedge clk);
        rst_assert_in = a;
        tx_en = en;
        @(negedge clk);
        for (int i = 0; i < HF_LEN; i++) begin
            tx_cw_stb   = 1'b1;
            tx_hf_start = synced && (i == 0);
            #1;
            chk(req, $sformatf("tx bit idx %0d", i), tx_rst_bit,
                synced && (i == SLOT_IDX) && a && en);
            @(negedge clk);
        end
        tx_cw_stb   = 1'b0;
        tx_hf_start = 1'b0;
        #1;
        chk("R9", "tx bit idle", tx_rst_bit, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "req in reset", rst_req_out, 1'b0);
        chk("R1", "raw in reset", rx_rst_raw, 1'b0);
        chk("R1", "tx in reset", tx_rst_bit, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "req after reset", rst_req_out, 1'b0);
    endtask

    task automatic t_unsynced();
        do_reset();
        rx_en = 1'b1;
        for (int k = 0; k < 3; k++) rx_hf(1'b1, 1'b1, 1'b0);
        chk("R2", "raw before sync", rx_rst_raw, 1'b0);
        chk("R2", "req before sync", rst_req_out, 1'b0);
        tx_hf(1'b1, 1'b1, 1'b0, "R2");
    endtask

    task automatic t_threshold();
        do_reset();
        rx_en = 1'b1;
        rx_run(REQ_COUNT - 1, 1'b1);
        chk("R3", "req after threshold-1", rst_req_out, 1'b0);
        chk("R7", "raw set", rx_rst_raw, 1'b1);
        rx_run(1, 1'b1);
        chk("R3", "req at threshold", rst_req_out, 1'b1);
        rx_run(2, 1'b1);
        chk("R5", "req held while set", rst_req_out, 1'b1);
        rx_run(1, 1'b0);
        chk("R5", "req falls on clear", rst_req_out, 1'b0);
        chk("R7", "raw cleared", rx_rst_raw, 1'b0);
    endtask

    task automatic t_broken_run();
        do_reset();
        rx_en = 1'b1;
        rx_run(REQ_COUNT - 1, 1'b1);
        rx_run(1, 1'b0);
        rx_run(REQ_COUNT - 1, 1'b1);
        chk("R4", "req after broken run", rst_req_out, 1'b0);
        rx_run(1, 1'b1);
        chk("R4", "req after fresh run", rst_req_out, 1'b1);
    endtask

    task automatic t_other_words();
        do_reset();
        rx_en = 1'b1;
        for (int k = 0; k < REQ_COUNT + 2; k++) rx_hf(1'b0, 1'b1, 1'b1);
        chk("R2", "req from non-slot bits", rst_req_out, 1'b0);
        chk("R2", "raw from non-slot bits", rx_rst_raw, 1'b0);
    endtask

    task automatic t_enable();
        do_reset();
        rx_en = 1'b0;
        rx_run(REQ_COUNT, 1'b1);
        chk("R6", "req gated while disabled", rst_req_out, 1'b0);
        @(negedge clk);
        rx_en = 1'b1;
        @(negedge clk);
        chk("R6", "req after re-enable", rst_req_out, 1'b1);
        rx_en = 1'b0;
        @(negedge clk);
        chk("R6", "req after disable", rst_req_out, 1'b0);
    endtask

    task automatic t_transmit();
        do_reset();
        tx_hf(1'b1, 1'b1, 1'b1, "R8");
        tx_hf(1'b0, 1'b1, 1'b1, "R8");
        tx_hf(1'b1, 1'b0, 1'b1, "R9");
        tx_hf(1'b1, 1'b1, 1'b1, "R8");
    endtask

    initial begin
        t_unsynced();
        t_threshold();
        t_broken_run();
        t_other_words();
        t_enable();
        t_transmit();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule